// File: doc/BRIEF.md
# In-Order Load Return Sequencer

This block sits between the load/store issue stage and the register write path of a pipelined core. Every memory operation presented at issue carries a tag, an access size, a signed flag, a data-cache hit indication and the three low address bits. Loads are tracked from issue until their data comes back. The block then produces exactly one return pulse per load, carrying its tag. Returns follow issue order strictly. The cache arrays, refill control and the sign extension of data are left to neighbouring logic.

Return latency depends on the load. A plain hit needs two cycles. A signed load narrower than a doubleword needs three. That slower timing also carries over to every load issued in an unbroken run of cycles directly behind it. A hit issued in the cycle right after a store pays a fixed extra penalty. A miss stays parked until the refill side pulses a completion, and every younger load waits behind it. Operations whose address is not a multiple of their access size are not tracked: they raise a trap pulse with their tag instead. When the tracking queue is full, the issue stage is held off.

Top module: `ld_return_seq`

## Requirements
- R1: An aligned load with `op_hit_i`=1 that is neither signed narrow nor in delayed mode, accepted in cycle c, gives `ret_valid_o`=1 with its tag in cycle c+2. A signed doubleword load also counts as not narrow.
- R2: An aligned hit with `op_signed_i`=1 and `op_size_i` of 0 (byte), 1 (halfword) or 2 (word) returns in cycle c+3. Size 3 is a doubleword.
- R3: Delayed mode is entered when a non-trapping signed narrow load is accepted. Each non-trapping load accepted in the cycle directly after a load that was slow keeps the mode and also uses the 3-cycle latency. The first cycle with no such load leaves the mode.
- R4: Returns come out in acceptance order, at most one per cycle. A miss (`op_hit_i`=0) returns in the cycle after the `miss_done_i` pulse that completes it, and no younger load returns before it.
- R5: Each `miss_done_i` pulse completes the oldest outstanding miss that is still incomplete. A pulse while no miss is incomplete has no effect.
- R6: A load is misaligned when any of its lowest size-many address bits is set. Those bits are 0 for a byte, bit 0 for a halfword, bits 1:0 for a word and bits 2:0 for a doubleword. A misaligned load accepted in cycle c gives `trap_o`=1 with its tag in cycle c+1, is not tracked, and never produces a return.
- R7: A store (`op_store_i`=1) never produces a return. A misaligned store traps exactly as in R6.
- R8: An aligned hit accepted in the cycle directly after an accepted aligned store returns 7 cycles later than R1 to R3 give.
- R9: `op_ready_o` is 0 exactly while 8 loads (DEPTH) are outstanding. An operation offered while `op_ready_o` is 0 is ignored: it is not tracked, it does not trap and it changes no mode.
- R10: During and right after reset, `ret_valid_o` and `trap_o` are 0 and `op_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Memory operation offered this cycle |
| op_store_i | input | 1 | 1 = store, 0 = load |
| op_tag_i | input | TAG_W | Operation tag |
| op_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| op_signed_i | input | 1 | Signed load |
| op_hit_i | input | 1 | Data cache hit |
| op_addr_lo_i | input | 3 | Low address bits |
| miss_done_i | input | 1 | Oldest incomplete miss has its data |
| op_ready_o | output | 1 | Operation can be accepted |
| ret_valid_o | output | 1 | Load data returns this cycle |
| ret_tag_o | output | TAG_W | Tag of the returning load |
| trap_o | output | 1 | Misaligned operation trap |
| trap_tag_o | output | TAG_W | Tag of the trapping operation |

## Verification
The hardest situation to reach from the ports is a full queue whose oldest entry is an incomplete miss, with completions then arriving while younger entries have long since finished their countdown. The stimulus issues eight consecutive misses to fill the queue. It offers one more operation while ready is low, and then releases the misses one pulse at a time, so the drain has to keep strict order. Delayed-mode chains and the store-to-hit penalty are driven as back-to-back operations with idle gaps placed so that each exit condition is exercised.

// File: rtl/ld_ret_pkg.sv
package ld_ret_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  function automatic logic is_misaligned(input logic [1:0] size, input logic [2:0] addr_lo);
    logic [2:0] mask;
    case (acc_size_e'(size))
      SZ_BYTE: mask = 3'b000;
      SZ_HALF: mask = 3'b001;
      SZ_WORD: mask = 3'b011;
      default: mask = 3'b111;
    endcase
    return |(addr_lo & mask);
  endfunction
endpackage

// File: rtl/lrs_issue_ctl.sv
module lrs_issue_ctl
  import ld_ret_pkg::*;
#(
  parameter int TAG_W      = 4,
  parameter int BASE_LAT   = 2,
  parameter int SLOW_LAT   = 3,
  parameter int ST_PENALTY = 7,
  parameter int CNT_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic             op_store_i,
  input  logic [TAG_W-1:0] op_tag_i,
  input  logic [1:0]       op_size_i,
  input  logic             op_signed_i,
  input  logic             op_hit_i,
  input  logic [2:0]       op_addr_lo_i,
  input  logic             ready_i,
  output logic             push_o,
  output logic [CNT_W-1:0] push_cnt_o,
  output logic             push_miss_o,
  output logic             trap_o,
  output logic [TAG_W-1:0] trap_tag_o
);
  logic acc, bad, ld_ok, st_ok, narrow_s, slow;
  logic dly_q, st_prev_q;

  assign acc      = op_valid_i & ready_i;
  assign bad      = is_misaligned(op_size_i, op_addr_lo_i);
  assign ld_ok    = acc & ~op_store_i & ~bad;
  assign st_ok    = acc & op_store_i & ~bad;
  assign narrow_s = op_signed_i & (acc_size_e'(op_size_i) != SZ_DBL);
  assign slow     = narrow_s | dly_q;

  // countdown start = latency - 1 (entry visible the cycle after issue)
  always_comb begin
    push_cnt_o = slow ? CNT_W'(SLOW_LAT - 1) : CNT_W'(BASE_LAT - 1);
    if (op_hit_i && st_prev_q) push_cnt_o = push_cnt_o + CNT_W'(ST_PENALTY);
  end

  assign push_o      = ld_ok;
  assign push_miss_o = ~op_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q      <= 1'b0;
      st_prev_q  <= 1'b0;
      trap_o     <= 1'b0;
      trap_tag_o <= '0;
    end else begin
      dly_q      <= ld_ok & slow;
      st_prev_q  <= st_ok;
      trap_o     <= acc & bad;
      trap_tag_o <= op_tag_i;
    end
  end
endmodule

// File: rtl/lrs_track_q.sv
module lrs_track_q #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  input  logic [CNT_W-1:0] push_cnt_i,
  input  logic             push_miss_i,
  input  logic             miss_done_i,
  output logic             full_o,
  output logic             ret_valid_o,
  output logic [TAG_W-1:0] ret_tag_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int OCC_W = PTR_W + 1;

  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [DEPTH-1:0] pend_q, done_sel;
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [OCC_W-1:0] occ_q;
  logic             pop;

  assign full_o      = (occ_q == OCC_W'(DEPTH));
  assign pop         = (occ_q != '0) && (cnt_q[rd_q] == '0) && !pend_q[rd_q];
  assign ret_valid_o = pop;
  assign ret_tag_o   = tag_q[rd_q];

  // oldest incomplete miss, scanning from head
  always_comb begin
    logic found;
    found    = 1'b0;
    done_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PTR_W-1:0] idx;
      idx = rd_q + PTR_W'(i);
      if (miss_done_i && !found && (OCC_W'(i) < occ_q) && pend_q[idx]) begin
        done_sel[idx] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_i && (wr_q == PTR_W'(i))) begin
          tag_q[i]  <= push_tag_i;
          cnt_q[i]  <= push_cnt_i;
          pend_q[i] <= push_miss_i;
        end else begin
          if (cnt_q[i] != '0) cnt_q[i] <= cnt_q[i] - 1'b1;
          if (done_sel[i]) pend_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + 1'b1;
      if (pop)    rd_q <= rd_q + 1'b1;
      occ_q <= occ_q + OCC_W'(push_i) - OCC_W'(pop);
    end
  end
endmodule

// File: rtl/ld_return_seq.sv
module ld_return_seq #(
  parameter int TAG_W      = 4,
  parameter int DEPTH      = 8,
  parameter int BASE_LAT   = 2,
  parameter int SLOW_LAT   = 3,
  parameter int ST_PENALTY = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic             op_store_i,
  input  logic [TAG_W-1:0] op_tag_i,
  input  logic [1:0]       op_size_i,
  input  logic             op_signed_i,
  input  logic             op_hit_i,
  input  logic [2:0]       op_addr_lo_i,
  input  logic             miss_done_i,
  output logic             op_ready_o,
  output logic             ret_valid_o,
  output logic [TAG_W-1:0] ret_tag_o,
  output logic             trap_o,
  output logic [TAG_W-1:0] trap_tag_o
);
  localparam int CNT_W = $clog2(SLOW_LAT + ST_PENALTY) + 1;

  logic             full, push, push_miss;
  logic [CNT_W-1:0] push_cnt;

  assign op_ready_o = ~full;

  lrs_issue_ctl #(
    .TAG_W(TAG_W), .BASE_LAT(BASE_LAT), .SLOW_LAT(SLOW_LAT),
    .ST_PENALTY(ST_PENALTY), .CNT_W(CNT_W)
  ) u_issue (
    .clk_i, .rst_ni, .op_valid_i, .op_store_i, .op_tag_i, .op_size_i,
    .op_signed_i, .op_hit_i, .op_addr_lo_i,
    .ready_i(op_ready_o), .push_o(push), .push_cnt_o(push_cnt),
    .push_miss_o(push_miss), .trap_o, .trap_tag_o
  );

  lrs_track_q #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni, .push_i(push), .push_tag_i(op_tag_i), .push_cnt_i(push_cnt),
    .push_miss_i(push_miss), .miss_done_i, .full_o(full),
    .ret_valid_o, .ret_tag_o
  );
endmodule

// File: rtl/ld_return_seq_chk.sv
module ld_return_seq_chk
  import ld_ret_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic             op_store_i,
  input logic [TAG_W-1:0] op_tag_i,
  input logic [1:0]       op_size_i,
  input logic             op_signed_i,
  input logic             op_hit_i,
  input logic [2:0]       op_addr_lo_i,
  input logic             miss_done_i,
  input logic             op_ready_o,
  input logic             ret_valid_o,
  input logic [TAG_W-1:0] ret_tag_o,
  input logic             trap_o,
  input logic [TAG_W-1:0] trap_tag_o
);
  localparam int OW = $clog2(DEPTH + 1) + 1;
  logic [OW-1:0] outst_q;
  logic          ld_acc;

  assign ld_acc = op_valid_i && op_ready_o && !op_store_i && !is_misaligned(op_size_i, op_addr_lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= '0;
    else         outst_q <= outst_q + OW'(ld_acc) - OW'(ret_valid_o);
  end

  AST_OUTST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst_q <= OW'(DEPTH)); // R9
  AST_READY_LOW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_ready_o |-> outst_q == OW'(DEPTH)); // R9
  AST_READY_HIGH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_ready_o |-> outst_q < OW'(DEPTH)); // R9
  AST_RET_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> outst_q != '0); // R4
  AST_MIN_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_valid_o && outst_q == OW'(1)) |-> !$past(ld_acc)); // R1
  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_valid_i && op_ready_o)); // R6
endmodule

bind ld_return_seq ld_return_seq_chk #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/ld_return_seq_tb.sv
module ld_return_seq_tb;
  localparam int TAG_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic op_valid_i = 0, op_store_i = 0, op_signed_i = 0, op_hit_i = 0, miss_done_i = 0;
  logic [TAG_W-1:0] op_tag_i = '0;
  logic [1:0] op_size_i = '0;
  logic [2:0] op_addr_lo_i = '0;
  logic op_ready_o, ret_valid_o, trap_o;
  logic [TAG_W-1:0] ret_tag_o, trap_tag_o;

  ld_return_seq #(.TAG_W(TAG_W)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  typedef struct { int tag; int due; bit miss; int avail; string req; } exp_t;
  typedef struct { int tag; int cyc; string req; } trp_t;
  exp_t rq[$];
  trp_t tq[$];
  int cyc = 0, checks = 0, failures = 0;
  int last_ld = -10, last_st = -10;
  bit last_slow = 0, mon_on = 0, done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic op(input bit st, input int tag, input int size, input bit sgn, input bit hit,
                    input int addr, input bit exp_rdy, input string req);
    bit bad, slow;
    int lat;
    @(negedge clk_i);
    op_valid_i = 1; op_store_i = st; op_tag_i = TAG_W'(tag); op_size_i = 2'(size);
    op_signed_i = sgn; op_hit_i = hit; op_addr_lo_i = 3'(addr); miss_done_i = 0;
    chk(op_ready_o == exp_rdy, exp_rdy ? req : "R9", "op_ready_o", op_ready_o, exp_rdy);
    if (op_ready_o) begin
      bad = (addr % (1 << size)) != 0;
      if (bad) tq.push_back('{tag, cyc + 1, req});
      else if (st) last_st = cyc;
      else begin
        slow = (sgn && size != 3) || (last_ld == cyc - 1 && last_slow);
        lat = slow ? 3 : 2;
        if (hit && last_st == cyc - 1) lat += 7;
        rq.push_back('{tag, cyc + lat, !hit, -1, req});
        last_ld = cyc; last_slow = slow;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      op_valid_i = 0; miss_done_i = 0;
    end
  endtask

  task automatic mdone();
    @(negedge clk_i);
    op_valid_i = 0; miss_done_i = 1;
    foreach (rq[i]) if (rq[i].miss && rq[i].avail < 0) begin
      rq[i].avail = cyc + 1;
      break;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) if (mon_on && !done) begin
    bit ev, et;
    ev = rq.size() > 0 && cyc >= rq[0].due &&
         (!rq[0].miss || (rq[0].avail >= 0 && cyc >= rq[0].avail));
    if (ev || ret_valid_o) begin
      chk(ev == ret_valid_o, ev ? rq[0].req : "R4", "ret_valid_o", ret_valid_o, ev);
      if (ev && ret_valid_o)
        chk(ret_tag_o == TAG_W'(rq[0].tag), rq[0].req, "ret_tag_o", ret_tag_o, rq[0].tag);
      if (ev) void'(rq.pop_front());
    end
    et = tq.size() > 0 && tq[0].cyc == cyc;
    if (et || trap_o) begin
      chk(et == trap_o, et ? tq[0].req : "R7", "trap_o", trap_o, et);
      if (et && trap_o)
        chk(trap_tag_o == TAG_W'(tq[0].tag), tq[0].req, "trap_tag_o", trap_tag_o, tq[0].tag);
      if (et) void'(tq.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!ret_valid_o && !trap_o && op_ready_o, "R10", "outputs in reset", {ret_valid_o, trap_o, op_ready_o}, 1);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!ret_valid_o && !trap_o && op_ready_o, "R10", "outputs after reset", {ret_valid_o, trap_o, op_ready_o}, 1);
    mon_on = 1;
    // R1 plain hits, signed doubleword counts as not narrow
    op(0, 1, 2, 0, 1, 0, 1, "R1"); idle(4);
    op(0, 2, 3, 1, 1, 0, 1, "R1"); idle(4);
    // R2 signed narrow loads
    op(0, 3, 0, 1, 1, 1, 1, "R2"); idle(4);
    op(0, 4, 2, 1, 1, 4, 1, "R2"); idle(4);
    // R3 delayed-mode chain and exit
    op(0, 5, 1, 1, 1, 2, 1, "R3");
    op(0, 6, 2, 0, 1, 0, 1, "R3");
    op(0, 7, 0, 0, 1, 3, 1, "R3");
    idle(1);
    op(0, 8, 3, 0, 1, 0, 1, "R3"); idle(5);
    // R4 miss holds younger hits
    op(0, 9, 2, 0, 0, 0, 1, "R4");
    op(0, 10, 2, 0, 1, 0, 1, "R4");
    op(0, 11, 1, 1, 1, 0, 1, "R4");
    idle(6); mdone(); idle(5);
    // R5 stray completion ignored, then two misses completed oldest first
    mdone(); idle(2);
    op(0, 12, 2, 0, 0, 0, 1, "R5");
    op(0, 13, 2, 0, 0, 0, 1, "R5");
    op(0, 14, 2, 0, 1, 0, 1, "R5");
    idle(4); mdone(); idle(3); mdone(); idle(5);
    // R6 misaligned loads trap, aligned neighbour returns
    op(0, 1, 1, 0, 1, 1, 1, "R6");
    op(0, 2, 3, 0, 1, 4, 1, "R6");
    op(0, 3, 2, 0, 1, 4, 1, "R6"); idle(5);
    // R7 stores: misaligned traps, aligned gives nothing
    op(1, 4, 2, 0, 1, 2, 1, "R7");
    op(1, 5, 3, 0, 1, 0, 1, "R7"); idle(5);
    // R8 hit right after store
    op(1, 6, 2, 0, 1, 0, 1, "R8");
    op(0, 7, 2, 0, 1, 0, 1, "R8"); idle(12);
    op(1, 8, 1, 0, 1, 0, 1, "R8");
    op(0, 9, 0, 1, 1, 0, 1, "R8"); idle(13);
    // R9 fill with misses, offer one more while full
    for (int i = 0; i < 8; i++) op(0, i, 2, 0, 0, 0, 1, "R9");
    op(0, 15, 0, 0, 1, 1, 0, "R9");
    idle(3);
    for (int i = 0; i < 8; i++) begin mdone(); idle(1); end
    idle(30);
    chk(rq.size() == 0, "R4", "pending returns at end", rq.size(), 0);
    chk(tq.size() == 0, "R6", "pending traps at end", tq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule